// File: doc/BRIEF.md
# Extended-Precision Narrowing Store Converter

This block turns an 80-bit extended-precision floating-point value into the 32-bit single or 64-bit double encoding used when a value is written to memory. The input holds the sign in bit 79, a 15-bit exponent with bias 16383 in bits 78:64, an explicit integer bit in bit 63 and a 63-bit fraction in bits 62:0. A per-operation select picks the destination format. A 2-bit rounding-control field picks the rounding direction. Two mask bits decide whether overflow and invalid-operation conditions still allow the store.

The converter is a single registered stage. A request accepted with `in_valid` produces its encoded word, its store-enable and its exception flags one clock later. Finite values are rounded and given the destination bias. Values below the destination's normal range become denormals or zero and raise underflow. Values above the range give infinity or the largest finite value and raise overflow. Zeros, infinities and quiet NaNs keep their class through plain truncation. Signaling NaNs and unsupported encodings raise invalid.

Top module: `xf_store_narrow`

## Requirements
- R1: Results appear one clock after `in_valid` is sampled high, with `out_valid` high for that single cycle. When `out_valid` is low, `store_en`, all flags and `out_data` are low.
- R2: With `dst_double`=0 the single result occupies `out_data[31:0]` and bits 63:32 are zero. With `dst_double`=1 the double result fills all 64 bits.
- R3: An exactly representable finite normal input keeps its sign and fraction bits, and its exponent is re-biased (input exponent − 16383 + 127 for single, + 1023 for double). No flag is raised.
- R4: Rounding of the discarded significand bits follows `rnd_ctl`: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. A carry out of the fraction increments the exponent.
- R5: `flag_inx` is set when any discarded significand bit is nonzero. `c1_up` is 1 only when the stored magnitude was rounded up, and is 0 otherwise.
- R6: A finite value whose rounded exponent reaches or exceeds the destination's all-ones exponent raises `flag_ovf` and `flag_inx`. With `mask_ovf`=1 the store holds infinity (nearest, or directed away from zero for the sign) with `c1_up`=1. In the other directions it holds the largest finite value of the input's sign with `c1_up`=0.
- R7: An overflow with `mask_ovf`=0 drives `store_en` low.
- R8: A nonzero finite value whose unrounded exponent falls below the smallest normal raises `flag_unf` and is stored as a denormal, a zero or, when rounding carries, the smallest normal. Inputs with a zero exponent field follow the same path. No other flag is raised except `flag_inx` and `c1_up` as in R5.
- R9: Zeros, infinities and quiet NaNs (input exponent all ones, integer bit 1, fraction bit 62 set) are stored with their sign, an all-ones or zero exponent as the class requires, and the top fraction bits truncated. No flag is raised.
- R10: A signaling NaN (exponent all ones, integer bit 1, bit 62 clear, fraction nonzero) raises `flag_inv`. With `mask_inv`=1 it is stored with the truncated payload and the top fraction bit set. With `mask_inv`=0, `store_en` is low.
- R11: Unsupported encodings (integer bit 0 with a nonzero exponent) raise `flag_inv`. With `mask_inv`=1 they store the default NaN: sign 1, exponent all ones, only the top fraction bit set. With `mask_inv`=0, `store_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Conversion request |
| in_value | input | 80 | Extended-precision source value |
| dst_double | input | 1 | 0 = single destination, 1 = double destination |
| rnd_ctl | input | 2 | Rounding direction |
| mask_ovf | input | 1 | 1 = overflow masked (store proceeds) |
| mask_inv | input | 1 | 1 = invalid masked (store proceeds) |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Encoded destination word |
| store_en | output | 1 | Result may be written |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow |
| flag_inx | output | 1 | Inexact |
| flag_inv | output | 1 | Invalid operation |
| c1_up | output | 1 | Significand was rounded up |

## Verification
The bench aims at exact ties with even and odd kept bits, where a design that rounds halves away from zero gives results one unit too large. It also covers rounding carries that walk into the exponent, both from the largest denormal into the smallest normal and from the largest finite value into overflow. A design that only tests the unrounded exponent would miss these carries. Further cases are tiny values at and beyond the shift range, including extended denormals, which a shifter that drops its sticky bits would store as an exact zero. Signaling NaNs with payload only in low bits must not collapse to infinity, and each masked overflow direction must choose correctly between infinity and the largest finite value.

// File: rtl/xfs_pkg.sv
`timescale 1ns/1ps
package xfs_pkg;

   parameter int XFS_DATA_W = 64;

   typedef enum logic [1:0] {
      RND_NEAR = 2'b00,
      RND_DOWN = 2'b01,
      RND_UP   = 2'b10,
      RND_ZERO = 2'b11
   } rnd_e;

   typedef enum logic [2:0] {
      CL_ZERO   = 3'd0,
      CL_FINITE = 3'd1,
      CL_INF    = 3'd2,
      CL_QNAN   = 3'd3,
      CL_SNAN   = 3'd4,
      CL_BAD    = 3'd5
   } cls_e;

   typedef struct packed {
      logic [XFS_DATA_W-1:0] data;
      logic                  ovf;
      logic                  unf;
      logic                  inx;
      logic                  inv;
      logic                  c1;
   } xfs_res_t;

endpackage

// File: rtl/xfs_classify.sv
`timescale 1ns/1ps
module xfs_classify
   import xfs_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int SIG_W = 64
) (
   input  logic [EXP_W-1:0] exp_i,
   input  logic [SIG_W-1:0] sig_i,
   output cls_e             cls_o
);

   localparam logic [EXP_W-1:0] EXP_ONES = '1;

   logic frac_zero;

   assign frac_zero = (sig_i[SIG_W-2:0] == '0);

   always_comb begin
      if (exp_i == EXP_ONES) begin
         if (!sig_i[SIG_W-1])        cls_o = CL_BAD;
         else if (frac_zero)         cls_o = CL_INF;
         else if (sig_i[SIG_W-2])    cls_o = CL_QNAN;
         else                        cls_o = CL_SNAN;
      end else if (exp_i == '0) begin
         if (sig_i == '0)            cls_o = CL_ZERO;
         else                        cls_o = CL_FINITE;
      end else begin
         if (!sig_i[SIG_W-1])        cls_o = CL_BAD;
         else                        cls_o = CL_FINITE;
      end
   end

endmodule

// File: rtl/xfs_narrow.sv
`timescale 1ns/1ps
module xfs_narrow
   import xfs_pkg::*;
#(
   parameter int SRC_EXP_W = 15,
   parameter int SIG_W     = 64,
   parameter int SRC_BIAS  = 16383,
   parameter int DST_EXP_W = 8,
   parameter int DST_FRC_W = 23
) (
   input  logic                 sign_i,
   input  logic [SRC_EXP_W-1:0] exp_i,
   input  logic [SIG_W-1:0]     sig_i,
   input  cls_e                 cls_i,
   input  rnd_e                 rnd_i,
   output xfs_res_t             res_o
);

   localparam int DST_W    = 1 + DST_EXP_W + DST_FRC_W;
   localparam int KEEP_W   = DST_FRC_W + 1;
   localparam int DST_BIAS = (2 ** (DST_EXP_W - 1)) - 1;
   localparam int EMAX     = (2 ** DST_EXP_W) - 1;
   localparam int WIDE_W   = 2 * SIG_W;
   localparam int SH_W     = $clog2(KEEP_W + 1);
   localparam int DE_W     = SRC_EXP_W + 3;
   localparam int MAG_W    = DST_EXP_W + DST_FRC_W;

   localparam logic signed [DE_W-1:0] DE_OFF  = DE_W'(SRC_BIAS - DST_BIAS);
   localparam logic signed [DE_W-1:0] DE_ONE  = DE_W'(1);
   localparam logic signed [DE_W-1:0] DE_ZERO = '0;
   localparam logic signed [DE_W-1:0] DE_EMAX = DE_W'(EMAX);
   localparam logic signed [DE_W-1:0] DE_KEEP = DE_W'(KEEP_W);
   localparam logic [DST_EXP_W-1:0]   EXP_ONES = '1;
   localparam logic [DST_EXP_W-1:0]   EXP_BIG  = EXP_ONES - 1'b1;

   if (DST_FRC_W + 2 > SIG_W) begin : g_bad_frc
      $error("xfs_narrow: destination fraction too wide for source significand");
   end
   if (DST_W > XFS_DATA_W) begin : g_bad_dst
      $error("xfs_narrow: destination word wider than result bus");
   end
   if (SRC_EXP_W < DST_EXP_W + 2) begin : g_bad_exp
      $error("xfs_narrow: source exponent must exceed destination exponent");
   end

   logic [SRC_EXP_W-1:0]   eff_exp;
   logic signed [DE_W-1:0] dexp;
   logic signed [DE_W-1:0] shift_full;
   logic                   tiny;
   logic                   huge;
   logic                   flush;
   logic [SH_W-1:0]        shamt;
   logic [WIDE_W-1:0]      wide;
   logic [KEEP_W-1:0]      kept;
   logic                   guard;
   logic                   sticky;
   logic                   lost;
   logic                   bump;
   logic [MAG_W-1:0]       mag_pre;
   logic [MAG_W-1:0]       mag_rnd;
   logic                   ovf;
   logic                   to_inf;
   logic [MAG_W-1:0]       mag_ovf;
   logic [DST_W-1:0]       word;

   // exponent of the value in destination bias; zero-exponent inputs share
   // the scale of exponent one
   assign eff_exp    = (exp_i == '0) ? SRC_EXP_W'(1) : exp_i;
   assign dexp       = $signed({{(DE_W - SRC_EXP_W){1'b0}}, eff_exp}) - DE_OFF;
   assign tiny       = (dexp <= DE_ZERO);
   assign huge       = (dexp >= DE_EMAX);
   assign shift_full = tiny ? (DE_ONE - dexp) : DE_ZERO;
   assign flush      = (shift_full > DE_KEEP);
   assign shamt      = flush ? SH_W'(0) : shift_full[SH_W-1:0];

   // alignment: nothing falls off the wide vector while shamt <= KEEP_W
   assign wide = {sig_i, {SIG_W{1'b0}}} >> shamt;

   always_comb begin
      if (flush) begin
         kept   = '0;
         guard  = 1'b0;
         sticky = 1'b1;
      end else begin
         kept   = wide[WIDE_W-1 -: KEEP_W];
         guard  = wide[WIDE_W-1-KEEP_W];
         sticky = |wide[WIDE_W-2-KEEP_W:0];
      end
   end

   assign lost = guard | sticky;

   always_comb begin
      unique case (rnd_i)
         RND_NEAR: bump = guard & (sticky | kept[0]);
         RND_DOWN: bump = sign_i & lost;
         RND_UP:   bump = ~sign_i & lost;
         default:  bump = 1'b0;
      endcase
   end

   // exponent and fraction as one field so a fraction carry lifts the exponent
   assign mag_pre = {(tiny ? {DST_EXP_W{1'b0}} : dexp[DST_EXP_W-1:0]), kept[DST_FRC_W-1:0]};
   assign mag_rnd = mag_pre + MAG_W'(bump);
   assign ovf     = huge | (mag_rnd[MAG_W-1 -: DST_EXP_W] == EXP_ONES);

   always_comb begin
      unique case (rnd_i)
         RND_NEAR: to_inf = 1'b1;
         RND_DOWN: to_inf = sign_i;
         RND_UP:   to_inf = ~sign_i;
         default:  to_inf = 1'b0;
      endcase
   end

   assign mag_ovf = to_inf ? {EXP_ONES, {DST_FRC_W{1'b0}}}
                           : {EXP_BIG, {DST_FRC_W{1'b1}}};

   always_comb begin
      word      = '0;
      res_o.ovf = 1'b0;
      res_o.unf = 1'b0;
      res_o.inx = 1'b0;
      res_o.inv = 1'b0;
      res_o.c1  = 1'b0;
      unique case (cls_i)
         CL_ZERO: word = {sign_i, {MAG_W{1'b0}}};
         CL_INF:  word = {sign_i, EXP_ONES, {DST_FRC_W{1'b0}}};
         CL_QNAN: word = {sign_i, EXP_ONES, sig_i[SIG_W-2 -: DST_FRC_W]};
         CL_SNAN: begin
            word      = {sign_i, EXP_ONES, 1'b1, sig_i[SIG_W-3 -: DST_FRC_W-1]};
            res_o.inv = 1'b1;
         end
         CL_BAD: begin
            word      = {1'b1, EXP_ONES, 1'b1, {(DST_FRC_W-1){1'b0}}};
            res_o.inv = 1'b1;
         end
         default: begin
            if (ovf) begin
               word      = {sign_i, mag_ovf};
               res_o.ovf = 1'b1;
               res_o.inx = 1'b1;
               res_o.c1  = to_inf;
            end else begin
               word      = {sign_i, mag_rnd};
               res_o.unf = tiny;
               res_o.inx = lost;
               res_o.c1  = bump;
            end
         end
      endcase
   end

   assign res_o.data = XFS_DATA_W'(word);

endmodule

// File: rtl/xf_store_narrow.sv
`timescale 1ns/1ps
module xf_store_narrow
   import xfs_pkg::*;
#(
   parameter int EXT_EXP_W = 15,
   parameter int EXT_SIG_W = 64,
   parameter int EXT_BIAS  = 16383,
   parameter int SGL_EXP_W = 8,
   parameter int SGL_FRC_W = 23,
   parameter int DBL_EXP_W = 11,
   parameter int DBL_FRC_W = 52,
   parameter int OUT_W     = 64,
   localparam int IN_W     = 1 + EXT_EXP_W + EXT_SIG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_value,
   input  logic             dst_double,
   input  logic [1:0]       rnd_ctl,
   input  logic             mask_ovf,
   input  logic             mask_inv,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data,
   output logic             store_en,
   output logic             flag_ovf,
   output logic             flag_unf,
   output logic             flag_inx,
   output logic             flag_inv,
   output logic             c1_up
);

   localparam int N_FMT = 2;

   if (OUT_W != XFS_DATA_W) begin : g_bad_out
      $error("xf_store_narrow: OUT_W must match the package result width");
   end
   if (1 + DBL_EXP_W + DBL_FRC_W > OUT_W) begin : g_bad_dbl
      $error("xf_store_narrow: double destination wider than output");
   end
   if (SGL_FRC_W >= DBL_FRC_W) begin : g_bad_order
      $error("xf_store_narrow: single format must be narrower than double");
   end

   logic                 src_sign;
   logic [EXT_EXP_W-1:0] src_exp;
   logic [EXT_SIG_W-1:0] src_sig;
   cls_e                 src_cls;
   rnd_e                 rnd;
   xfs_res_t             fmt_res [N_FMT];
   xfs_res_t             sel;
   logic                 allow;

   assign src_sign = in_value[IN_W-1];
   assign src_exp  = in_value[IN_W-2 -: EXT_EXP_W];
   assign src_sig  = in_value[EXT_SIG_W-1:0];
   assign rnd      = rnd_e'(rnd_ctl);

   xfs_classify #(
      .EXP_W (EXT_EXP_W),
      .SIG_W (EXT_SIG_W)
   ) classify_i (
      .exp_i (src_exp),
      .sig_i (src_sig),
      .cls_o (src_cls)
   );

   for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
      localparam int EW = (g == 0) ? SGL_EXP_W : DBL_EXP_W;
      localparam int FW = (g == 0) ? SGL_FRC_W : DBL_FRC_W;
      xfs_narrow #(
         .SRC_EXP_W (EXT_EXP_W),
         .SIG_W     (EXT_SIG_W),
         .SRC_BIAS  (EXT_BIAS),
         .DST_EXP_W (EW),
         .DST_FRC_W (FW)
      ) narrow_i (
         .sign_i (src_sign),
         .exp_i  (src_exp),
         .sig_i  (src_sig),
         .cls_i  (src_cls),
         .rnd_i  (rnd),
         .res_o  (fmt_res[g])
      );
   end

   assign sel   = dst_double ? fmt_res[1] : fmt_res[0];
   assign allow = !(sel.ovf && !mask_ovf) && !(sel.inv && !mask_inv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         store_en  <= 1'b0;
         flag_ovf  <= 1'b0;
         flag_unf  <= 1'b0;
         flag_inx  <= 1'b0;
         flag_inv  <= 1'b0;
         c1_up     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_data  <= in_valid ? sel.data : '0;
         store_en  <= in_valid & allow;
         flag_ovf  <= in_valid & sel.ovf;
         flag_unf  <= in_valid & sel.unf;
         flag_inx  <= in_valid & sel.inx;
         flag_inv  <= in_valid & sel.inv;
         c1_up     <= in_valid & sel.c1;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !store_en && !flag_ovf && !flag_unf && !flag_inx && !flag_inv && !c1_up) // R1
      else $error("idle output not quiet");

   AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid) && !$past(dst_double) |-> out_data[OUT_W-1:32] == '0) // R2
      else $error("single result leaks into upper half");

   AST_C1_NEEDS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && c1_up |-> flag_inx) // R5
      else $error("round-up reported on exact result");

   AST_OVF_UNMASKED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid) && !$past(mask_ovf) && flag_ovf |-> !store_en) // R7
      else $error("unmasked overflow still stored");

   AST_UNF_EXCLUDES_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(flag_unf && flag_ovf)) // R8
      else $error("underflow and overflow together");

   AST_INV_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flag_inv |-> !flag_ovf && !flag_unf && !flag_inx && !c1_up) // R10
      else $error("invalid combined with numeric flags");

   AST_INV_UNMASKED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid) && !$past(mask_inv) && flag_inv |-> !store_en) // R11
      else $error("unmasked invalid still stored");

endmodule

// File: tb/xf_store_narrow_tb_top.sv
`timescale 1ns/1ps
module xf_store_narrow_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [79:0] in_value = '0;
   logic        dst_double = 1'b0;
   logic [1:0]  rnd_ctl = 2'b00;
   logic        mask_ovf = 1'b1;
   logic        mask_inv = 1'b1;
   logic        out_valid;
   logic [63:0] out_data;
   logic        store_en;
   logic        flag_ovf, flag_unf, flag_inx, flag_inv, c1_up;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   xf_store_narrow dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_value   (in_value),
      .dst_double (dst_double),
      .rnd_ctl    (rnd_ctl),
      .mask_ovf   (mask_ovf),
      .mask_inv   (mask_inv),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .store_en   (store_en),
      .flag_ovf   (flag_ovf),
      .flag_unf   (flag_unf),
      .flag_inx   (flag_inx),
      .flag_inv   (flag_inv),
      .c1_up      (c1_up)
   );

   // flags packed as {ovf, unf, inx, inv, c1}
   task automatic check(input string req, input logic [63:0] exp_data,
                        input logic exp_store, input logic [4:0] exp_flags);
      logic [4:0] got_flags;
      got_flags = {flag_ovf, flag_unf, flag_inx, flag_inv, c1_up};
      checks++;
      if (!out_valid || out_data !== exp_data || store_en !== exp_store ||
          got_flags !== exp_flags) begin
         fails++;
         $display("FAIL %s: valid=%b data=%h store=%b flags=%b expected valid=1 data=%h store=%b flags=%b",
                  req, out_valid, out_data, store_en, got_flags, exp_data, exp_store, exp_flags);
      end
   endtask

   task automatic convert(input logic s, input logic [14:0] e, input logic [63:0] m,
                          input logic dbl, input logic [1:0] rc,
                          input logic mo, input logic mi);
      @(negedge clk);
      in_value   = {s, e, m};
      dst_double = dbl;
      rnd_ctl    = rc;
      mask_ovf   = mo;
      mask_inv   = mi;
      in_valid   = 1'b1;
      @(negedge clk);
      in_valid   = 1'b0;
   endtask

   task automatic t_reset;
      checks++;
      if (out_valid !== 1'b0 || store_en !== 1'b0 || out_data !== '0) begin
         fails++;
         $display("FAIL R1 reset: valid=%b store=%b data=%h expected 0 0 0", out_valid, store_en, out_data);
      end
   endtask

   task automatic t_timing;
      convert(0, 15'h3FFF, 64'h8000_0000_0000_0000, 0, 2'b00, 1, 1);
      check("R1 one-cycle result", 64'h3F80_0000, 1, 5'b00000);
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || store_en !== 1'b0 || out_data !== '0) begin
         fails++;
         $display("FAIL R1 drop: valid=%b store=%b data=%h expected 0 0 0", out_valid, store_en, out_data);
      end
   endtask

   task automatic t_exact;
      convert(0, 15'h3FFF, 64'h8000_0000_0000_0000, 1, 2'b00, 1, 1);
      check("R2 R3 1.0 double", 64'h3FF0_0000_0000_0000, 1, 5'b00000);
      convert(1, 15'h4000, 64'hA000_0000_0000_0000, 0, 2'b00, 1, 1);
      check("R2 R3 -2.5 single", 64'h0000_0000_C020_0000, 1, 5'b00000);
      convert(1, 15'h4000, 64'hA000_0000_0000_0000, 1, 2'b11, 1, 1);
      check("R3 -2.5 double", 64'hC004_0000_0000_0000, 1, 5'b00000);
      convert(0, 15'h407E, 64'hFFFF_FF00_0000_0000, 0, 2'b10, 1, 1);
      check("R3 largest single exact", 64'h7F7F_FFFF, 1, 5'b00000);
   endtask

   task automatic t_round_single;
      convert(0, 15'h3FFF, 64'h8000_0080_0000_0000, 0, 2'b00, 1, 1);
      check("R4 R5 tie even stays", 64'h3F80_0000, 1, 5'b00100);
      convert(0, 15'h3FFF, 64'h8000_0080_0000_0000, 0, 2'b10, 1, 1);
      check("R4 R5 up", 64'h3F80_0001, 1, 5'b00101);
      convert(0, 15'h3FFF, 64'h8000_0080_0000_0000, 0, 2'b01, 1, 1);
      check("R4 down positive", 64'h3F80_0000, 1, 5'b00100);
      convert(0, 15'h3FFF, 64'h8000_0080_0000_0000, 0, 2'b11, 1, 1);
      check("R4 toward zero", 64'h3F80_0000, 1, 5'b00100);
      convert(0, 15'h3FFF, 64'h8000_0180_0000_0000, 0, 2'b00, 1, 1);
      check("R4 tie odd rounds up", 64'h3F80_0002, 1, 5'b00101);
      convert(1, 15'h3FFF, 64'h8000_0080_0000_0000, 0, 2'b01, 1, 1);
      check("R4 R5 down negative", 64'hBF80_0001, 1, 5'b00101);
      convert(0, 15'h3FFF, 64'hFFFF_FF80_0000_0000, 0, 2'b00, 1, 1);
      check("R4 carry into exponent", 64'h4000_0000, 1, 5'b00101);
   endtask

   task automatic t_round_double;
      convert(0, 15'h3FFF, 64'h8000_0000_0000_0400, 1, 2'b00, 1, 1);
      check("R4 double tie even", 64'h3FF0_0000_0000_0000, 1, 5'b00100);
      convert(0, 15'h3FFF, 64'h8000_0000_0000_0400, 1, 2'b10, 1, 1);
      check("R4 R5 double up", 64'h3FF0_0000_0000_0001, 1, 5'b00101);
   endtask

   task automatic t_overflow;
      convert(0, 15'h407F, 64'h8000_0000_0000_0000, 0, 2'b00, 1, 1);
      check("R6 nearest to inf", 64'h7F80_0000, 1, 5'b10101);
      convert(0, 15'h407F, 64'h8000_0000_0000_0000, 0, 2'b11, 1, 1);
      check("R6 toward zero max", 64'h7F7F_FFFF, 1, 5'b10100);
      convert(1, 15'h407F, 64'h8000_0000_0000_0000, 0, 2'b01, 1, 1);
      check("R6 neg down to inf", 64'hFF80_0000, 1, 5'b10101);
      convert(1, 15'h407F, 64'h8000_0000_0000_0000, 0, 2'b10, 1, 1);
      check("R6 neg up max", 64'hFF7F_FFFF, 1, 5'b10100);
      convert(0, 15'h407E, 64'hFFFF_FF80_0000_0000, 0, 2'b00, 1, 1);
      check("R6 rounding carry overflow", 64'h7F80_0000, 1, 5'b10101);
      convert(0, 15'h43FF, 64'h8000_0000_0000_0000, 1, 2'b00, 1, 1);
      check("R6 double overflow", 64'h7FF0_0000_0000_0000, 1, 5'b10101);
      convert(0, 15'h407F, 64'h8000_0000_0000_0000, 0, 2'b00, 0, 1);
      check("R7 unmasked overflow", 64'h7F80_0000, 0, 5'b10101);
   endtask

   task automatic t_underflow;
      convert(0, 15'h3F80, 64'h8000_0000_0000_0000, 0, 2'b00, 1, 1);
      check("R8 exact denormal", 64'h0040_0000, 1, 5'b01000);
      convert(0, 15'h3F6A, 64'h8000_0000_0000_0000, 0, 2'b00, 1, 1);
      check("R8 smallest denormal", 64'h0000_0001, 1, 5'b01000);
      convert(0, 15'h3F69, 64'h8000_0000_0000_0000, 0, 2'b00, 1, 1);
      check("R8 half ulp tie to zero", 64'h0000_0000, 1, 5'b01100);
      convert(0, 15'h3F69, 64'h8000_0000_0000_0000, 0, 2'b10, 1, 1);
      check("R8 half ulp up", 64'h0000_0001, 1, 5'b01101);
      convert(0, 15'h3F80, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'b00, 1, 1);
      check("R8 carry to min normal", 64'h0080_0000, 1, 5'b01101);
      convert(1, 15'h0000, 64'h0000_0000_0000_0001, 0, 2'b00, 1, 1);
      check("R8 extended denormal nearest", 64'h8000_0000, 1, 5'b01100);
      convert(1, 15'h0000, 64'h0000_0000_0000_0001, 0, 2'b01, 1, 1);
      check("R8 extended denormal down", 64'h8000_0001, 1, 5'b01101);
   endtask

   task automatic t_specials;
      convert(0, 15'h0000, 64'h0, 0, 2'b10, 1, 1);
      check("R9 +0 single", 64'h0000_0000, 1, 5'b00000);
      convert(1, 15'h0000, 64'h0, 1, 2'b00, 1, 1);
      check("R9 -0 double", 64'h8000_0000_0000_0000, 1, 5'b00000);
      convert(1, 15'h7FFF, 64'h8000_0000_0000_0000, 0, 2'b11, 1, 1);
      check("R9 -inf single", 64'hFF80_0000, 1, 5'b00000);
      convert(0, 15'h7FFF, 64'hE000_0000_0000_0123, 0, 2'b00, 1, 1);
      check("R9 qnan single", 64'h7FE0_0000, 1, 5'b00000);
      convert(0, 15'h7FFF, 64'hE000_0000_0000_0123, 1, 2'b00, 1, 1);
      check("R9 qnan double", 64'h7FFC_0000_0000_0000, 1, 5'b00000);
   endtask

   task automatic t_snan;
      convert(0, 15'h7FFF, 64'hA000_0000_0000_0000, 0, 2'b00, 1, 1);
      check("R10 masked snan quieted", 64'h7FE0_0000, 1, 5'b00010);
      convert(0, 15'h7FFF, 64'h8000_0000_0000_0001, 1, 2'b00, 1, 1);
      check("R10 low payload snan", 64'h7FF8_0000_0000_0000, 1, 5'b00010);
      convert(0, 15'h7FFF, 64'hA000_0000_0000_0000, 0, 2'b00, 1, 0);
      check("R10 unmasked snan", 64'h7FE0_0000, 0, 5'b00010);
   endtask

   task automatic t_unsupported;
      convert(0, 15'h3FFF, 64'h4000_0000_0000_0000, 0, 2'b00, 1, 1);
      check("R11 unnormal single", 64'hFFC0_0000, 1, 5'b00010);
      convert(0, 15'h7FFF, 64'h0, 1, 2'b00, 1, 1);
      check("R11 pseudo-inf double", 64'hFFF8_0000_0000_0000, 1, 5'b00010);
      convert(0, 15'h7FFF, 64'h0, 1, 2'b00, 1, 0);
      check("R11 unmasked unsupported", 64'hFFF8_0000_0000_0000, 0, 5'b00010);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_timing();
      t_exact();
      t_round_single();
      t_round_double();
      t_overflow();
      t_underflow();
      t_specials();
      t_snan();
      t_unsupported();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule